// File: doc/BRIEF.md
# Multi-Function Pad Control Unit

This block owns one external pad and decides, from a single per-pad configuration word, which of eight internal peripheral sources drives it. In normal operation the selected source supplies the pad data, output enable and pull requests. When the chip enters a low-power state, the configuration can replace the source with fixed sleep values held in the register. Pull resistors are controlled either by the selected source or by two register bits, and pull-up wins if both are asked for.

The pad input is synchronised and watched for rising and falling edges. A detected edge sets a sticky status flag, which software clears by pulsing a write-one-to-clear input. The flag becomes a wake-up request only while an external per-peripheral wake enable is high. A three-bit drive-strength code is stored and exported unchanged to the analog pad cell. The reset input is expected to arrive already released synchronously to `clk`.

Top module: `pad_mux_ctrl`

## Requirements
- R1: After reset the configuration reads back 0x0000_0C40 (source 0, drive code 3, edge detection disabled via bit 6, sleep select off). A write stores the 16-bit data with bit 3 forced to 0; read data bits 31:16 and bit 3 are always 0.
- R2: Bits 2:0 choose source N (0 to 7); outside the sleep override, pad_out equals func_out[N] and pad_oe equals func_oe[N].
- R3: While lp_mode is 1 and bit 9 is 1, pad_oe equals the inverse of bit 7 and pad_out equals bit 8; with bit 9 at 0, or with lp_mode at 0, the selected source drives the pad.
- R4: With bit 15 at 0, pad_pu and pad_pd follow func_pu[N] and func_pd[N] of the selected source.
- R5: With bit 15 at 1, bit 14 requests pull-up and bit 13 requests pull-down, independently of the sources.
- R6: pad_pu and pad_pd are never both 1; when both are requested, only pad_pu is asserted.
- R7: With bit 4 set and bit 6 clear, a 0-to-1 change of pad_in (driven between clock edges) sets edge_flag on the third rising clock edge after the change, not before.
- R8: With bit 5 set and bit 6 clear, a 1-to-0 change of pad_in sets edge_flag; with only bit 4 set a falling change is not recorded, and with only bit 5 set a rising change is not recorded.
- R9: While bit 6 is 1, no edge is recorded regardless of bits 4 and 5.
- R10: edge_flag stays 1 until a cycle with edge_clr at 1 clears it; if an edge is detected in the same cycle as the clear, the flag stays 1.
- R11: wake_req is 1 exactly when edge_flag is 1 and wake_en is 1.
- R12: drive_code always equals configuration bits 12:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| edge_clr | input | 1 | Write-one-to-clear strobe for the edge flag |
| func_out | input | 8 | Data from each of the eight sources |
| func_oe | input | 8 | Output enable from each source |
| func_pu | input | 8 | Pull-up request from each source |
| func_pd | input | 8 | Pull-down request from each source |
| lp_mode | input | 1 | Chip is in a low-power state |
| pad_in | input | 1 | Asynchronous input from the pad |
| pad_out | output | 1 | Data to the pad |
| pad_oe | output | 1 | Output enable to the pad |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| drive_code | output | 3 | Stored drive-strength and slew code |
| wake_en | input | 1 | External wake enable for this peripheral |
| edge_flag | output | 1 | Sticky edge-detected status |
| wake_req | output | 1 | Wake-up request |

## Verification
The edge detector setting the sticky flag and a software clear of that flag can land in the same clock cycle. The bench provokes this by changing pad_in, counting two rising clock edges so the synchroniser shows the change, and raising edge_clr for exactly the third edge, when the detection is applied. It judges the result by edge_flag remaining 1 afterwards, then confirms that a lone clear pulse drops it to 0.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

  localparam int CFG_W  = 16;
  localparam int AF_W   = 3;
  localparam int NUM_AF = 1 << AF_W;
  localparam int DRV_W  = 3;

  // Bit 3 is reserved and never stored.
  localparam logic [CFG_W-1:0] CFG_MASK  = 16'hFFF7;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0C40;

  // Field layout, MSB first, matches the software-visible bit positions.
  typedef struct packed {
    logic             pull_own;   // 15: 1 = register owns pulls
    logic             pull_up;    // 14
    logic             pull_dn;    // 13
    logic [DRV_W-1:0] drv;        // 12:10
    logic             slp_sel;    // 9
    logic             slp_dat;    // 8
    logic             slp_oe_n;   // 7
    logic             edge_off;   // 6
    logic             edge_fall;  // 5
    logic             edge_rise;  // 4
    logic             rsvd;       // 3
    logic [AF_W-1:0]  af;         // 2:0
  } pad_cfg_t;

endpackage

// File: rtl/pad_cfg_reg.sv
module pad_cfg_reg
  import pad_mux_pkg::*;
#(
  parameter int RD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output pad_cfg_t         cfg,
  output logic [RD_W-1:0]  rdata
);

  localparam int PAD_W = RD_W - CFG_W;

  pad_cfg_t cfg_q;
  pad_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d = pad_cfg_t'(wdata & CFG_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= pad_cfg_t'(CFG_RESET);
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD_W{1'b0}}, cfg_q};

  assert_write_stored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == ($past(wdata) & CFG_MASK)));

  assert_hold_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));

endmodule

// File: rtl/pad_out_sel.sv
module pad_out_sel
  import pad_mux_pkg::*;
(
  input  logic [AF_W-1:0]   af,
  input  logic              lp_mode,
  input  logic              slp_sel,
  input  logic              slp_dat,
  input  logic              slp_oe_n,
  input  logic              pull_own,
  input  logic              pull_up,
  input  logic              pull_dn,
  input  logic [NUM_AF-1:0] func_out,
  input  logic [NUM_AF-1:0] func_oe,
  input  logic [NUM_AF-1:0] func_pu,
  input  logic [NUM_AF-1:0] func_pd,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_pu,
  output logic              pad_pd
);

  logic sel_out, sel_oe, sel_pu, sel_pd;
  logic req_pu, req_pd;
  logic override;

  // Source mux
  always_comb begin
    sel_out = func_out[af];
    sel_oe  = func_oe[af];
    sel_pu  = func_pu[af];
    sel_pd  = func_pd[af];
  end

  // Low-power substitution
  assign override = lp_mode & slp_sel;

  always_comb begin
    if (override) begin
      pad_out = slp_dat;
      pad_oe  = ~slp_oe_n;
    end else begin
      pad_out = sel_out;
      pad_oe  = sel_oe;
    end
  end

  // Pull ownership, then pull-up priority
  always_comb begin
    if (pull_own) begin
      req_pu = pull_up;
      req_pd = pull_dn;
    end else begin
      req_pu = sel_pu;
      req_pd = sel_pd;
    end
    pad_pu = req_pu;
    pad_pd = req_pd & ~req_pu;
  end

endmodule

// File: rtl/pad_edge_det.sv
module pad_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic rise_en,
  input  logic fall_en,
  input  logic det_off,
  input  logic clr,
  output logic flag
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   flag_q;
  logic                   flag_d;
  logic                   level;
  logic                   rise, fall, hit;

  // Synchroniser chain
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[g] <= 1'b0;
        end else begin
          sync_q[g] <= (g == 0) ? pad_in : sync_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
    end else begin
      last_q <= level;
    end
  end

  assign rise = level & ~last_q;
  assign fall = ~level & last_q;
  assign hit  = ~det_off & ((rise & rise_en) | (fall & fall_en));

  // Sticky status: a new detection outranks a clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (clr) begin
      flag_d = 1'b0;
    end
    if (hit) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit || clr) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> flag_q);

  assert_clear_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);

  assert_disabled_no_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_off && !flag_q) |=> !flag_q);

endmodule

// File: rtl/pad_mux_ctrl.sv
module pad_mux_ctrl
  import pad_mux_pkg::*;
#(
  parameter int RD_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [RD_W-1:0]   cfg_rdata,
  input  logic              edge_clr,
  input  logic [NUM_AF-1:0] func_out,
  input  logic [NUM_AF-1:0] func_oe,
  input  logic [NUM_AF-1:0] func_pu,
  input  logic [NUM_AF-1:0] func_pd,
  input  logic              lp_mode,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_pu,
  output logic              pad_pd,
  output logic [DRV_W-1:0]  drive_code,
  input  logic              wake_en,
  output logic              edge_flag,
  output logic              wake_req
);

  pad_cfg_t cfg;

  pad_cfg_reg #(.RD_W(RD_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  pad_out_sel u_sel (
    .af       (cfg.af),
    .lp_mode  (lp_mode),
    .slp_sel  (cfg.slp_sel),
    .slp_dat  (cfg.slp_dat),
    .slp_oe_n (cfg.slp_oe_n),
    .pull_own (cfg.pull_own),
    .pull_up  (cfg.pull_up),
    .pull_dn  (cfg.pull_dn),
    .func_out (func_out),
    .func_oe  (func_oe),
    .func_pu  (func_pu),
    .func_pd  (func_pd),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd)
  );

  pad_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .rise_en (cfg.edge_rise),
    .fall_en (cfg.edge_fall),
    .det_off (cfg.edge_off),
    .clr     (edge_clr),
    .flag    (edge_flag)
  );

  assign drive_code = cfg.drv;
  assign wake_req   = edge_flag & wake_en;

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rsvd == 1'b0) && (cfg_rdata[RD_W-1:CFG_W] == '0));

  assert_pull_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd));

  assert_wake_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_en && edge_flag));

  assert_drive_tracks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    drive_code == cfg_rdata[12:10]);

endmodule

// File: tb/test_pad_mux_ctrl.sv
`timescale 1ns/1ps
module test_pad_mux_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        edge_clr;
  logic [7:0]  func_out, func_oe, func_pu, func_pd;
  logic        lp_mode, pad_in;
  logic        pad_out, pad_oe, pad_pu, pad_pd;
  logic [2:0]  drive_code;
  logic        wake_en, edge_flag, wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pad_mux_ctrl i_pad_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .edge_clr(edge_clr), .func_out(func_out),
    .func_oe(func_oe), .func_pu(func_pu), .func_pd(func_pd),
    .lp_mode(lp_mode), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .drive_code(drive_code),
    .wake_en(wake_en), .edge_flag(edge_flag), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0; #1;
  endtask

  task automatic clr_pulse();
    @(negedge clk); edge_clr = 1'b1;
    @(negedge clk); edge_clr = 1'b0; #1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic test_reset();
    chk("R1 reset readback", cfg_rdata, 32'h0000_0C40);
    chk("R12 reset drive", {29'd0, drive_code}, 32'd3);
    chk("R10 reset flag", {31'd0, edge_flag}, 32'd0);
    wr(16'hFFFF);
    chk("R1 reserved bits zero", cfg_rdata, 32'h0000_FFF7);
  endtask

  task automatic test_af_mux();
    func_out = 8'b1010_0110; func_oe = 8'b0111_0001;
    func_pu = 8'h00; func_pd = 8'h00; lp_mode = 1'b0;
    for (int n = 0; n < 8; n++) begin
      wr(16'h0040 | 16'(n));
      chk("R2 pad_out", {31'd0, pad_out}, {31'd0, func_out[n]});
      chk("R2 pad_oe", {31'd0, pad_oe}, {31'd0, func_oe[n]});
    end
    func_out = ~func_out;
    #1 chk("R2 follows source", {31'd0, pad_out}, {31'd0, func_out[7]});
  endtask

  task automatic test_sleep();
    func_out = 8'h00; func_oe = 8'h00;
    // source 2, sleep select, data 1, oe_n 0
    wr(16'h0342);
    lp_mode = 1'b0; #1;
    chk("R3 run ignores sleep", {30'd0, pad_out, pad_oe}, 32'd0);
    lp_mode = 1'b1; #1;
    chk("R3 sleep drive", {30'd0, pad_out, pad_oe}, 32'd3);
    wr(16'h03C2);  // oe_n=1, data 1
    chk("R3 sleep oe off", {30'd0, pad_out, pad_oe}, 32'd2);
    wr(16'h0142);  // select off while in low power
    chk("R3 no select uses source", {30'd0, pad_out, pad_oe}, 32'd0);
    lp_mode = 1'b0;
  endtask

  task automatic test_pull();
    func_pu = 8'b0000_0100; func_pd = 8'b0000_1100;
    wr(16'h0042);  // source 2: pu and pd both
    chk("R6 source both -> pu", {30'd0, pad_pu, pad_pd}, 32'd2);
    wr(16'h0043);  // source 3: pd only
    chk("R4 source pd", {30'd0, pad_pu, pad_pd}, 32'd1);
    wr(16'h0041);
    chk("R4 source none", {30'd0, pad_pu, pad_pd}, 32'd0);
    wr(16'hA041);  // register owned, pd
    chk("R5 reg pd", {30'd0, pad_pu, pad_pd}, 32'd1);
    wr(16'hC043);  // register owned, pu, source 3 pd ignored
    chk("R5 reg pu", {30'd0, pad_pu, pad_pd}, 32'd2);
    wr(16'hE041);
    chk("R6 reg both -> pu", {30'd0, pad_pu, pad_pd}, 32'd2);
  endtask

  task automatic test_rise();
    pad_in = 1'b0; wr(16'h0010); settle(); clr_pulse();
    @(negedge clk); pad_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R7 not yet after two edges", {31'd0, edge_flag}, 32'd0);
    @(posedge clk); @(negedge clk); #1;
    chk("R7 flag on third edge", {31'd0, edge_flag}, 32'd1);
    clr_pulse();
    @(negedge clk); pad_in = 1'b0; settle();
    chk("R8 rise-only ignores fall", {31'd0, edge_flag}, 32'd0);
  endtask

  task automatic test_fall();
    wr(16'h0020); pad_in = 1'b0; settle(); clr_pulse();
    @(negedge clk); pad_in = 1'b1; settle();
    chk("R8 fall-only ignores rise", {31'd0, edge_flag}, 32'd0);
    @(negedge clk); pad_in = 1'b0; settle();
    chk("R8 fall recorded", {31'd0, edge_flag}, 32'd1);
    clr_pulse();
    chk("R10 clear", {31'd0, edge_flag}, 32'd0);
  endtask

  task automatic test_disable();
    wr(16'h0070); pad_in = 1'b0; settle(); clr_pulse();
    @(negedge clk); pad_in = 1'b1; settle();
    @(negedge clk); pad_in = 1'b0; settle();
    chk("R9 disabled no record", {31'd0, edge_flag}, 32'd0);
  endtask

  task automatic test_collision();
    wr(16'h0010); pad_in = 1'b0; settle(); clr_pulse();
    @(negedge clk); pad_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); edge_clr = 1'b1;   // covers the third edge
    @(negedge clk); edge_clr = 1'b0; #1;
    chk("R10 set wins over clear", {31'd0, edge_flag}, 32'd1);
    repeat (3) @(negedge clk); #1;
    chk("R10 sticky", {31'd0, edge_flag}, 32'd1);
  endtask

  task automatic test_wake();
    wake_en = 1'b0; #1;
    chk("R11 gated off", {31'd0, wake_req}, 32'd0);
    wake_en = 1'b1; #1;
    chk("R11 gated on", {31'd0, wake_req}, 32'd1);
    clr_pulse();
    chk("R11 no flag no wake", {31'd0, wake_req}, 32'd0);
    wake_en = 1'b0;
  endtask

  task automatic test_drive();
    for (int d = 0; d < 8; d++) begin
      wr(16'(d) << 10);
      chk("R12 drive code", {29'd0, drive_code}, 32'(d));
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; edge_clr = 1'b0;
    func_out = '0; func_oe = '0; func_pu = '0; func_pd = '0;
    lp_mode = 1'b0; pad_in = 1'b0; wake_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    test_reset();
    test_af_mux();
    test_sleep();
    test_pull();
    test_rise();
    test_fall();
    test_disable();
    test_collision();
    test_wake();
    test_drive();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=running expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule